// File: doc/BRIEF.md
# Up/Down Reload-Capture Timer

This block is a 16-bit timer/counter paired with a 16-bit reload/capture register. The count advances on an internal tick, which fires once every `PRESCALE` clocks, or on falling edges of an external event pin. A control byte selects one of four behaviours. In capture mode a falling edge on a second external pin (the control pin) snapshots the count. In auto-reload mode the count is refilled from the reload register on overflow, and can also be refilled on a control-pin edge; an up/down variant lets the control-pin level choose the direction. In rate-generator mode each rollover produces a one-cycle baud tick and never sets the overflow flag. In clock-out mode each rollover toggles an output pin.

Software reaches the control byte, the mode byte, the two count bytes and the two reload bytes through a simple byte-wide write port and a combinational read port. Two sticky flags report events: an overflow flag and an external-event flag. The consumer of the baud tick and any interrupt logic sit outside the block.

Top module: `urt_timer`

## Requirements
- R1: After a synchronous reset every register reads 0, and `ovf_flag`, `ext_flag`, `baud_tick` and `clk_out` are low.
- R2: Register addresses: 0 = control, 1 = mode, 2/3 = count low/high, 4/5 = reload low/high. Control bits, from bit 7 down: overflow flag, external flag, receive-rate enable, transmit-rate enable, external-trigger enable, run, event-count select, capture select. Mode bit 1 enables clock-out and mode bit 0 enables up/down counting. Mode bits 7..2 read as 0.
- R3: With run set and event-count select clear, the count advances once every `PRESCALE` clocks. With run clear (and external trigger disabled) the count holds.
- R4: With event-count select set and run set, the count advances once per falling edge of `evt_pin`. Edges are found by comparing two successive registered samples.
- R5: In auto-reload mode, an increment from 0xFFFF loads the reload value and sets the overflow flag.
- R6: In auto-reload mode with external-trigger enable set, a falling edge on `ctl_pin` loads the count from the reload register and sets the external flag. With the enable clear, the edge changes nothing.
- R7: In capture mode with external-trigger enable set, a falling edge on `ctl_pin` copies the count into the reload register and sets the external flag. The count wraps from 0xFFFF to 0 and sets the overflow flag.
- R8: With up/down enabled in auto-reload mode, a high `ctl_pin` counts up and a low one counts down. Counting up from 0xFFFF loads the reload value. Counting down onto the reload value loads 0xFFFF. Each such wrap sets the overflow flag and inverts the external flag.
- R9: With either rate enable set, a rollover from 0xFFFF loads the reload value and raises `baud_tick` for exactly one cycle. The overflow flag is never set in this mode.
- R10: With clock-out enabled, each rollover reloads and toggles `clk_out`. The output period is 4·(65536 − reload) clocks when `PRESCALE` is 2.
- R11: The flags are sticky. Only hardware events set them (the up/down wrap also inverts the external flag), and a write to the control byte loads them, which is how software clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (3) | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | AW (3) | Register read address |
| rd_data | output | 8 | Combinational read data |
| evt_pin | input | 1 | External event input for event-count mode |
| ctl_pin | input | 1 | External trigger/direction input |
| ovf_flag | output | 1 | Sticky overflow flag |
| ext_flag | output | 1 | Sticky external-event flag |
| baud_tick | output | 1 | One-cycle pulse per rollover in rate-generator mode |
| clk_out | output | 1 | Toggling clock output |

## Verification
A register write takes effect at the clock edge that samples it. Each count step appears one clock after the internal tick and at least two clocks after an event-pin edge. A control-pin fall is acted on at the second edge after the pin changes, because two registered samples must disagree first. The bench reproduces these latencies with its own behavioural model, stepped on every rising edge, and compares all outputs and the currently addressed register a few nanoseconds after each edge. Its directed checks wait at least three falling edges after any pin stimulus before sampling, and it measures the clock-out half-period edge to edge against the formula.

// File: rtl/urt_pkg.sv
package urt_pkg;

    // Register addresses whose position is fixed by the map
    localparam int A_CTRL = 0;
    localparam int A_MODE = 1;
    localparam int A_CNT0 = 2;

    // Configuration held outside the flags
    typedef struct packed {
        logic rx_rate;
        logic tx_rate;
        logic trig_en;
        logic run;
        logic evt_sel;
        logic cap_sel;
        logic clkout_en;
        logic updown_en;
    } cfg_t;

    typedef enum logic [1:0] {
        OP_RATE    = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_UPDOWN  = 2'd2,
        OP_RELOAD  = 2'd3
    } op_mode_t;

    // Priority: rate/clock-out > capture > up/down > plain reload
    function automatic op_mode_t pick_mode(cfg_t c);
        if (c.rx_rate || c.tx_rate || c.clkout_en) return OP_RATE;
        if (c.cap_sel)                             return OP_CAPTURE;
        if (c.updown_en)                           return OP_UPDOWN;
        return OP_RELOAD;
    endfunction

endpackage

// File: rtl/urt_sampler.sv
module urt_sampler #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin,
    output logic [W-1:0] cur,
    output logic [W-1:0] prev
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur  <= '0;
            prev <= '0;
        end else begin
            cur  <= pin;
            prev <= cur;
        end
    end
endmodule

// File: rtl/urt_prescale.sv
module urt_prescale #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (DIV <= 1) begin : g_pass
            assign tick = run;
        end else begin : g_div
            localparam int PW = $clog2(DIV);
            localparam logic [PW-1:0] LAST = PW'(DIV - 1);
            logic [PW-1:0] phase;
            always_ff @(posedge clk) begin
                if (rst || !run) phase <= '0;
                else if (phase == LAST) phase <= '0;
                else phase <= phase + PW'(1);
            end
            assign tick = run && (phase == LAST);
        end
    endgenerate
endmodule

// File: rtl/urt_engine.sv
module urt_engine
    import urt_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8,
    localparam int NB    = CNT_W / BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  cfg_t              cfg,
    input  logic              tick,
    input  logic              ext_fall,
    input  logic              dir_up,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [NB-1:0]     cnt_we,
    input  logic [NB-1:0]     rld_we,
    input  logic              flag_we,
    input  logic [1:0]        flag_wdata,
    output logic [CNT_W-1:0]  cnt,
    output logic [CNT_W-1:0]  rld,
    output logic              ovf_f,
    output logic              ext_f,
    output logic              baud_tick,
    output logic              clk_out
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic [CNT_W-1:0] cnt_n, rld_n;
    logic             ovf_n, ext_n, bt_n, co_n;
    logic             at_top, at_floor, trig;

    assign at_top   = (cnt == TOP);
    assign at_floor = (cnt == rld);
    assign trig     = cfg.trig_en && ext_fall;

    always_comb begin
        cnt_n = cnt;
        rld_n = rld;
        ovf_n = ovf_f;
        ext_n = ext_f;
        bt_n  = 1'b0;
        co_n  = clk_out;

        // software writes first; hardware events below take precedence
        if (flag_we) begin
            ovf_n = flag_wdata[1];
            ext_n = flag_wdata[0];
        end
        for (int b = 0; b < NB; b++) begin
            if (cnt_we[b]) cnt_n[b*BYTE_W +: BYTE_W] = wr_data;
            if (rld_we[b]) rld_n[b*BYTE_W +: BYTE_W] = wr_data;
        end

        unique case (pick_mode(cfg))
            OP_RATE: begin
                if (tick) begin
                    if (at_top) begin
                        cnt_n = rld;
                        bt_n  = cfg.rx_rate || cfg.tx_rate;
                        if (cfg.clkout_en) co_n = ~clk_out;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
                if (trig) ext_n = 1'b1;
            end
            OP_CAPTURE: begin
                if (tick) begin
                    cnt_n = cnt + CNT_W'(1);
                    if (at_top) ovf_n = 1'b1;
                end
                if (trig) begin
                    rld_n = cnt;
                    ext_n = 1'b1;
                end
            end
            OP_UPDOWN: begin
                if (tick) begin
                    if (dir_up) begin
                        if (at_top) begin
                            cnt_n = rld;
                            ovf_n = 1'b1;
                            ext_n = ~ext_f;
                        end else begin
                            cnt_n = cnt + CNT_W'(1);
                        end
                    end else begin
                        if (at_floor) begin
                            cnt_n = TOP;
                            ovf_n = 1'b1;
                            ext_n = ~ext_f;
                        end else begin
                            cnt_n = cnt - CNT_W'(1);
                        end
                    end
                end
            end
            default: begin
                if (trig) begin
                    cnt_n = rld;
                    ext_n = 1'b1;
                end else if (tick) begin
                    if (at_top) begin
                        cnt_n = rld;
                        ovf_n = 1'b1;
                    end else begin
                        cnt_n = cnt + CNT_W'(1);
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            rld       <= '0;
            ovf_f     <= 1'b0;
            ext_f     <= 1'b0;
            baud_tick <= 1'b0;
            clk_out   <= 1'b0;
        end else begin
            cnt       <= cnt_n;
            rld       <= rld_n;
            ovf_f     <= ovf_n;
            ext_f     <= ext_n;
            baud_tick <= bt_n;
            clk_out   <= co_n;
        end
    end
endmodule

// File: rtl/urt_timer.sv
module urt_timer
    import urt_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int BYTE_W   = 8,
    parameter int PRESCALE = 2,
    localparam int NB      = CNT_W / BYTE_W,
    localparam int NREG    = 2 + 2 * NB,
    localparam int AW      = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              evt_pin,
    input  logic              ctl_pin,
    output logic              ovf_flag,
    output logic              ext_flag,
    output logic              baud_tick,
    output logic              clk_out
);
    localparam int A_RLD0 = A_CNT0 + NB;

    cfg_t             cfg_q;
    logic [1:0]       pin_cur, pin_prev;
    logic             ctl_fall, evt_fall, int_tick, cnt_tick;
    logic             ctrl_wr, mode_wr;
    logic [NB-1:0]    cnt_we, rld_we;
    logic [CNT_W-1:0] cnt_q, rld_q;

    assign ctrl_wr = wr_en && (wr_addr == AW'(A_CTRL));
    assign mode_wr = wr_en && (wr_addr == AW'(A_MODE));

    generate
        for (genvar b = 0; b < NB; b++) begin : g_lane
            assign cnt_we[b] = wr_en && (wr_addr == AW'(A_CNT0 + b));
            assign rld_we[b] = wr_en && (wr_addr == AW'(A_RLD0 + b));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (ctrl_wr) begin
                cfg_q.rx_rate <= wr_data[5];
                cfg_q.tx_rate <= wr_data[4];
                cfg_q.trig_en <= wr_data[3];
                cfg_q.run     <= wr_data[2];
                cfg_q.evt_sel <= wr_data[1];
                cfg_q.cap_sel <= wr_data[0];
            end
            if (mode_wr) begin
                cfg_q.clkout_en <= wr_data[1];
                cfg_q.updown_en <= wr_data[0];
            end
        end
    end

    // bit 0: control pin, bit 1: event pin
    urt_sampler #(.W(2)) u_samp (
        .clk  (clk),
        .rst  (rst),
        .pin  ({evt_pin, ctl_pin}),
        .cur  (pin_cur),
        .prev (pin_prev)
    );
    assign ctl_fall = pin_prev[0] && !pin_cur[0];
    assign evt_fall = pin_prev[1] && !pin_cur[1];

    urt_prescale #(.DIV(PRESCALE)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (cfg_q.run),
        .tick (int_tick)
    );
    assign cnt_tick = cfg_q.run && (cfg_q.evt_sel ? evt_fall : int_tick);

    urt_engine #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_eng (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg_q),
        .tick       (cnt_tick),
        .ext_fall   (ctl_fall),
        .dir_up     (pin_cur[0]),
        .wr_data    (wr_data),
        .cnt_we     (cnt_we),
        .rld_we     (rld_we),
        .flag_we    (ctrl_wr),
        .flag_wdata (wr_data[7:6]),
        .cnt        (cnt_q),
        .rld        (rld_q),
        .ovf_f      (ovf_flag),
        .ext_f      (ext_flag),
        .baud_tick  (baud_tick),
        .clk_out    (clk_out)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == AW'(A_CTRL))
            rd_data = BYTE_W'({ovf_flag, ext_flag, cfg_q.rx_rate, cfg_q.tx_rate,
                               cfg_q.trig_en, cfg_q.run, cfg_q.evt_sel, cfg_q.cap_sel});
        if (rd_addr == AW'(A_MODE))
            rd_data = BYTE_W'({cfg_q.clkout_en, cfg_q.updown_en});
        for (int b = 0; b < NB; b++) begin
            if (rd_addr == AW'(A_CNT0 + b)) rd_data = cnt_q[b*BYTE_W +: BYTE_W];
            if (rd_addr == AW'(A_RLD0 + b)) rd_data = rld_q[b*BYTE_W +: BYTE_W];
        end
    end
endmodule

// File: rtl/urt_checker.sv
module urt_checker #(
    parameter int CNT_W = 16,
    parameter int AW    = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [AW-1:0]    wr_addr,
    input logic             ovf_flag,
    input logic             ext_flag,
    input logic             baud_tick,
    input logic             clk_out,
    input logic             run,
    input logic             trig_en,
    input logic             rate_act,
    input logic             co_en,
    input logic             updown_act,
    input logic [CNT_W-1:0] cnt
);
    logic ctrl_wr;
    assign ctrl_wr = wr_en && (wr_addr == '0);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ovf_flag && !ext_flag && !baud_tick && !clk_out));

    // R3
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !trig_en && !wr_en) |=> $stable(cnt));

    // R9
    rate_no_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ovf_flag) && !$past(ctrl_wr)) |-> !$past(rate_act));

    // R9
    tick_single_chk: assert property (@(posedge clk) disable iff (rst)
        baud_tick |=> !baud_tick);

    // R10
    clkout_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(clk_out) |-> $past(co_en));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf_flag) |-> $past(ctrl_wr));

    // R11
    ext_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(ext_flag) |-> ($past(ctrl_wr) || $past(updown_act)));
endmodule

bind urt_timer urt_checker #(.CNT_W(CNT_W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .ovf_flag   (ovf_flag),
    .ext_flag   (ext_flag),
    .baud_tick  (baud_tick),
    .clk_out    (clk_out),
    .run        (cfg_q.run),
    .trig_en    (cfg_q.trig_en),
    .rate_act   (cfg_q.rx_rate | cfg_q.tx_rate),
    .co_en      (cfg_q.clkout_en),
    .updown_act (cfg_q.updown_en),
    .cnt        (cnt_q)
);

// File: tb/tb_urt_timer.sv
module tb_urt_timer;
    localparam int PRE = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       evt_pin = 1'b0;
    logic       ctl_pin = 1'b0;
    logic       ovf_flag, ext_flag, baud_tick, clk_out;

    int tests = 0;
    int fails = 0;
    bit rd_hold = 1'b0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    urt_timer #(.PRESCALE(PRE)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .evt_pin(evt_pin), .ctl_pin(ctl_pin),
        .ovf_flag(ovf_flag), .ext_flag(ext_flag), .baud_tick(baud_tick), .clk_out(clk_out)
    );

    // ---------------- behavioural reference ----------------
    logic        m_ovf, m_ext, m_bt, m_co, m_coen, m_ud;
    logic [5:0]  m_ctl;   // rx tx trig run evt cap
    logic [15:0] m_cnt, m_rld;
    logic [1:0]  m_s1, m_s2;
    int          m_pre;

    always @(posedge clk) begin : model
        logic [15:0] nc, nr;
        logic no, ne, nb, nco, cf, kf, up, it, tk, trg;
        if (rst) begin
            m_ovf = 0; m_ext = 0; m_bt = 0; m_co = 0; m_coen = 0; m_ud = 0;
            m_ctl = 0; m_cnt = 0; m_rld = 0; m_s1 = 0; m_s2 = 0; m_pre = 0;
        end else begin
            cf  = m_s2[0] && !m_s1[0];
            kf  = m_s2[1] && !m_s1[1];
            up  = m_s1[0];
            it  = m_ctl[2] && (m_pre == PRE - 1);
            tk  = m_ctl[2] && (m_ctl[1] ? kf : it);
            trg = m_ctl[3] && cf;
            nc = m_cnt; nr = m_rld; no = m_ovf; ne = m_ext; nb = 0; nco = m_co;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: begin no = wr_data[7]; ne = wr_data[6]; end
                    3'd2: nc[7:0]  = wr_data;
                    3'd3: nc[15:8] = wr_data;
                    3'd4: nr[7:0]  = wr_data;
                    3'd5: nr[15:8] = wr_data;
                    default: ;
                endcase
            end
            if (m_ctl[5] || m_ctl[4] || m_coen) begin
                if (tk) begin
                    if (m_cnt == 16'hFFFF) begin
                        nc = m_rld; nb = m_ctl[5] || m_ctl[4];
                        if (m_coen) nco = !m_co;
                    end else nc = m_cnt + 16'd1;
                end
                if (trg) ne = 1;
            end else if (m_ctl[0]) begin
                if (tk) begin nc = m_cnt + 16'd1; if (m_cnt == 16'hFFFF) no = 1; end
                if (trg) begin nr = m_cnt; ne = 1; end
            end else if (m_ud) begin
                if (tk && up) begin
                    if (m_cnt == 16'hFFFF) begin nc = m_rld; no = 1; ne = !m_ext; end
                    else nc = m_cnt + 16'd1;
                end else if (tk) begin
                    if (m_cnt == m_rld) begin nc = 16'hFFFF; no = 1; ne = !m_ext; end
                    else nc = m_cnt - 16'd1;
                end
            end else begin
                if (trg) begin nc = m_rld; ne = 1; end
                else if (tk) begin
                    if (m_cnt == 16'hFFFF) begin nc = m_rld; no = 1; end
                    else nc = m_cnt + 16'd1;
                end
            end
            m_s2 = m_s1;
            m_s1 = {evt_pin, ctl_pin};
            m_pre = !m_ctl[2] ? 0 : ((m_pre == PRE - 1) ? 0 : m_pre + 1);
            if (wr_en && wr_addr == 3'd0) m_ctl = wr_data[5:0];
            if (wr_en && wr_addr == 3'd1) {m_coen, m_ud} = wr_data[1:0];
            m_cnt = nc; m_rld = nr; m_ovf = no; m_ext = ne; m_bt = nb; m_co = nco;
        end
    end

    function automatic logic [7:0] mread(logic [2:0] a);
        case (a)
            3'd0: return {m_ovf, m_ext, m_ctl};
            3'd1: return {6'd0, m_coen, m_ud};
            3'd2: return m_cnt[7:0];
            3'd3: return m_cnt[15:8];
            3'd4: return m_rld[7:0];
            3'd5: return m_rld[15:8];
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
        end
    endtask

    // rotate read address, then compare everything a few ns after each edge
    always @(posedge clk) begin
        #1;
        if (!rd_hold) rd_addr <= (rd_addr == 3'd5) ? 3'd0 : rd_addr + 3'd1;
        #2;
        if (!rst && !done)
            chk(cur_req, {20'd0, rd_data, ovf_flag, ext_flag, baud_tick, clk_out},
                {20'd0, mread(rd_addr), m_ovf, m_ext, m_bt, m_co});
    end

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rdchk(string req, logic [2:0] a, logic [7:0] exp);
        rd_hold = 1; rd_addr = a;
        #1 chk(req, rd_data, exp);
        rd_hold = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ctl_drop;
        @(negedge clk) ctl_pin = 1;
        idle(3);
        ctl_pin = 0;
        idle(4);
    endtask

    initial begin : wdog
        #(8 * 200000);
        fails++; tests++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : stim
        logic [7:0] v1;
        int n, nt;
        logic prev;
        idle(3);
        @(negedge clk) rst = 0;
        idle(1);
        // R1 reset state
        cur_req = "R1";
        chk("R1", {ovf_flag, ext_flag, baud_tick, clk_out}, 4'b0);
        for (int a = 0; a < 6; a++) rdchk("R1", 3'(a), 8'h00);

        // R2 register map
        cur_req = "R2";
        wr(4, 8'hF0); wr(5, 8'hFF); wr(2, 8'hF8); wr(3, 8'hFF);
        rdchk("R2", 2, 8'hF8); rdchk("R2", 3, 8'hFF);
        rdchk("R2", 4, 8'hF0); rdchk("R2", 5, 8'hFF);
        wr(1, 8'hFE); rdchk("R2", 1, 8'h02);
        wr(1, 8'h00);

        // R3 / R5 timer run and reload on overflow
        cur_req = "R5";
        wr(0, 8'h04);
        idle(40);
        chk("R5", ovf_flag, 1'b1);
        chk("R11", ovf_flag, 1'b1);
        cur_req = "R3";
        wr(0, 8'h00);
        chk("R11", ovf_flag, 1'b0);
        rdchk("R5", 3, 8'hFF);
        rd_hold = 1; rd_addr = 2; #1 v1 = rd_data;
        idle(10);
        #1 chk("R3", rd_data, v1);
        rd_hold = 0;

        // R6 external reload
        cur_req = "R6";
        wr(0, 8'h08); wr(2, 8'h34); wr(3, 8'h12);
        ctl_drop;
        rdchk("R6", 2, 8'hF0); rdchk("R6", 3, 8'hFF);
        chk("R6", ext_flag, 1'b1);
        wr(0, 8'h00);
        chk("R11", ext_flag, 1'b0);
        wr(2, 8'h34); wr(3, 8'h12);
        ctl_drop;
        rdchk("R6", 2, 8'h34); rdchk("R6", 3, 8'h12);
        chk("R6", ext_flag, 1'b0);

        // R7 capture
        cur_req = "R7";
        wr(0, 8'h09); wr(2, 8'hCD); wr(3, 8'hAB);
        ctl_drop;
        rdchk("R7", 4, 8'hCD); rdchk("R7", 5, 8'hAB);
        chk("R7", ext_flag, 1'b1);
        @(negedge clk) ctl_pin = 1;
        wr(2, 8'hFC); wr(3, 8'hFF);
        wr(0, 8'h0D);
        idle(20);
        chk("R7", ovf_flag, 1'b1);
        rdchk("R7", 3, 8'h00);
        wr(0, 8'h00);

        // R4 event counting
        cur_req = "R4";
        wr(2, 8'h00); wr(3, 8'h00);
        wr(0, 8'h06);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk) evt_pin = 1;
            idle(2);
            evt_pin = 0;
            idle(2);
        end
        idle(3);
        rdchk("R4", 2, 8'h05);
        wr(0, 8'h00);

        // R8 up/down
        cur_req = "R8";
        wr(1, 8'h01); wr(4, 8'h10); wr(5, 8'h00); wr(2, 8'h14); wr(3, 8'h00);
        @(negedge clk) ctl_pin = 0;
        idle(3);
        wr(0, 8'h04);
        idle(16);
        chk("R8", ovf_flag, 1'b1);
        chk("R8", ext_flag, 1'b1);
        rdchk("R8", 3, 8'hFF);
        ctl_pin = 1;
        idle(30);
        chk("R8", ext_flag, 1'b0);
        rdchk("R8", 3, 8'h00);
        wr(0, 8'h00); wr(1, 8'h00);

        // R9 rate generator
        cur_req = "R9";
        wr(4, 8'hF8); wr(5, 8'hFF); wr(2, 8'hF8); wr(3, 8'hFF);
        wr(0, 8'h24);
        idle(5);
        nt = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (baud_tick) nt++;
        end
        chk("R9", nt, 4);
        chk("R9", ovf_flag, 1'b0);
        wr(0, 8'h00);

        // R10 clock-out
        cur_req = "R10";
        wr(4, 8'hF0); wr(5, 8'hFF); wr(2, 8'hF0); wr(3, 8'hFF);
        wr(1, 8'h02);
        wr(0, 8'h04);
        prev = clk_out; n = 0;
        while (clk_out == prev && n < 500) begin @(negedge clk); n++; end
        prev = clk_out; n = 0;
        while (clk_out == prev && n < 500) begin @(negedge clk); n++; end
        chk("R10", n, 2 * (65536 - 32'hFFF0));

        idle(2);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule